// File: doc/BRIEF.md
# Segmented Paged Address Translator

This unit turns a 20-bit virtual address into a 20-bit physical address for one load or store at a time. The top two address bits pick one of four segment descriptors, which are held in registers and written through a dedicated port. Each descriptor holds three things: the byte address where that segment's page table starts, how many page entries the table holds, and whether the segment is usable at all. The next six bits pick a page inside the segment. The low twelve bits are the byte offset within a 4096-byte page, and they pass through unchanged.

The segment checks come first. If they pass, the unit reads the two-byte page entry from a byte-wide memory over a read port with one cycle of latency. The entry is stored with its most significant byte first. The unit then checks the entry's permission bits. It reports one result per request: either the physical address, or one of three fault codes, which are ranked in a fixed order of precedence. It accepts a new request only when it is idle.

Top module: `seg_page_xlat`

## Requirements
- R1: A successful translation returns a physical address whose upper 8 bits are the high byte of the page entry and whose lower 12 bits equal virtual address bits [11:0]. The virtual address splits into a segment in bits [19:18], a page in bits [17:12] and an offset in bits [11:0].
- R2: A write on the segment port with the enable high replaces the descriptor selected by the index. The descriptor holds a 20-bit table base, a 7-bit page count and a valid flag. Requests issued after the write use the new descriptor.
- R3: A request to a segment whose valid flag is clear finishes with error code 01 and a physical address of zero, and the memory is not read.
- R4: A request to a valid segment whose page number is greater than or equal to the segment's page count finishes with error code 10, and the memory is not read. A page count of 0 rejects every page, and a page count of 64 admits page 63. An invalid segment reports 01 even when its page is also out of range.
- R5: The page entry is read at base + 2*page, with the sum modulo 2^20. The unit reads the high byte at that address in the first cycle after the segment check, then the low byte at address + 1 in the next cycle.
- R6: If bit 0 (Valid) of the entry's low byte is clear, the request finishes with error code 11 and a physical address of zero. This holds for both loads and stores.
- R7: A store to a page whose low-byte bit 1 (Writeable) is clear finishes with error code 11. A load to the same page succeeds. Bits 7 down to 2 of the low byte do not affect the result.
- R8: Each request ends with `done` high for exactly one cycle. At that point `errCode` is 00 on success, or the fault code. If the request is accepted at clock edge E, `done` is high after edge E+1 for segment faults and after edge E+3 for requests that read the table.
- R9: `reqReady` is high only while the unit is idle. A request presented while `reqReady` is low is ignored, and the request already in progress completes with its own address.
- R10: After reset the unit is idle, `done` and `memRdEn` are low, and all four segments are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| segWrEn | input | 1 | Write strobe for a segment descriptor |
| segWrIdx | input | 2 | Descriptor to write |
| segWrBase | input | 20 | Page table base byte address |
| segWrLimit | input | 7 | Number of page entries (0 to 64) |
| segWrValid | input | 1 | Segment usable flag |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqStore | input | 1 | 1 for store, 0 for load |
| reqVaddr | input | 20 | Virtual address |
| reqReady | output | 1 | Unit idle and able to take a request |
| memRdEn | output | 1 | Byte read strobe |
| memRdAddr | output | 20 | Byte read address |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| done | output | 1 | One-cycle result strobe |
| errCode | output | 2 | 00 ok, 01 bad segment, 10 segment overflow, 11 access violation |
| paddr | output | 20 | Physical address (zero on a fault) |

## Verification
The bench tests the edges of the page-count comparison: the last legal page, the first illegal page, a count of zero and a count of 64. A design that used a strict comparison, or truncated the count to six bits, would pass an overflowing page or reject a legal one. It also tests an invalid segment whose page is also out of range, and a page table whose start lies two bytes below the top of the address space so that the entry address wraps. Under a wrong precedence the first case would report an overflow, and the second would read the wrong bytes. It also checks a store against a read-only page next to a load of the same page, and an entry whose unused flag bits are all set; it holds the request strobe high for a full busy period and rewrites the descriptors between requests. A design that ignored Writeable, decoded the wrong flag bits, or let a second request in while busy would return a wrong code or address, or pulse `done` at the wrong time.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RDHI,
    ST_RDLO
  } xlat_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic issueHi;
    logic issueLo;
    logic capHi;
    logic finishSeg;
    logic finishPte;
  } xlat_ctrl_t;

  localparam logic [1:0] ERR_OK     = 2'b00;
  localparam logic [1:0] ERR_BADSEG = 2'b01;
  localparam logic [1:0] ERR_OVER   = 2'b10;
  localparam logic [1:0] ERR_ACCESS = 2'b11;

  // positions inside the low byte of a page entry
  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_WRITE_BIT = 1;

endpackage

// File: rtl/xlat_control.sv
module xlat_control
  import xlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       segFault,
  output logic       reqReady,
  output xlat_ctrl_t ctrl
);

  xlat_state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          stateNext     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (segFault) begin
          ctrl.finishSeg = 1'b1;
          stateNext      = ST_IDLE;
        end else begin
          ctrl.issueHi = 1'b1;
          stateNext    = ST_RDHI;
        end
      end
      ST_RDHI: begin
        ctrl.capHi   = 1'b1;
        ctrl.issueLo = 1'b1;
        stateNext    = ST_RDLO;
      end
      ST_RDLO: begin
        ctrl.finishPte = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);

  // R9: an accepted request makes the unit busy on the next cycle
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

  // R8: a table walk finishes exactly two cycles after its first read
  assert_walk_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RDHI) |=> (state == ST_RDLO));

endmodule

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int PAGE_W = 6,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 8,
  localparam int VA_W  = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LIM_W = PAGE_W + 1,
  localparam int NSEG  = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlat_ctrl_t       ctrl,
  input  logic             segWrEn,
  input  logic [SEG_W-1:0] segWrIdx,
  input  logic [PA_W-1:0]  segWrBase,
  input  logic [LIM_W-1:0] segWrLimit,
  input  logic             segWrValid,
  input  logic             reqStore,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [PPN_W-1:0] memRdData,
  output logic             segFault,
  output logic             memRdEn,
  output logic [PA_W-1:0]  memRdAddr,
  output logic             done,
  output logic [1:0]       errCode,
  output logic [PA_W-1:0]  paddr
);

  logic [PA_W-1:0]  segBase  [NSEG];
  logic [LIM_W-1:0] segLimit [NSEG];
  logic [NSEG-1:0]  segValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSEG; i++) begin
        segBase[i]  <= '0;
        segLimit[i] <= '0;
      end
      segValid <= '0;
    end else if (segWrEn) begin
      segBase[segWrIdx]  <= segWrBase;
      segLimit[segWrIdx] <= segWrLimit;
      segValid[segWrIdx] <= segWrValid;
    end
  end

  logic [VA_W-1:0] vaQ;
  logic            storeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ    <= '0;
      storeQ <= 1'b0;
    end else if (ctrl.latchReq) begin
      vaQ    <= reqVaddr;
      storeQ <= reqStore;
    end
  end

  logic [SEG_W-1:0]  segIdx;
  logic [PAGE_W-1:0] pageNum;
  logic [OFF_W-1:0]  offset;
  logic              segBad, segOver;
  logic [PA_W-1:0]   pteAddr;

  assign segIdx  = vaQ[VA_W-1 -: SEG_W];
  assign pageNum = vaQ[OFF_W +: PAGE_W];
  assign offset  = vaQ[OFF_W-1:0];
  assign segBad  = !segValid[segIdx];
  assign segOver = {1'b0, pageNum} >= segLimit[segIdx];
  assign segFault = segBad || segOver;
  assign pteAddr = segBase[segIdx] + PA_W'({pageNum, 1'b0});

  assign memRdEn   = ctrl.issueHi || ctrl.issueLo;
  assign memRdAddr = pteAddr + PA_W'(ctrl.issueLo);

  logic [PPN_W-1:0] ppnQ;
  logic             pteDenied;

  assign pteDenied = !memRdData[PTE_VALID_BIT] ||
                     (storeQ && !memRdData[PTE_WRITE_BIT]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppnQ    <= '0;
      done    <= 1'b0;
      errCode <= ERR_OK;
      paddr   <= '0;
    end else begin
      done <= ctrl.finishSeg || ctrl.finishPte;
      if (ctrl.capHi) ppnQ <= memRdData;
      if (ctrl.finishSeg) begin
        errCode <= segBad ? ERR_BADSEG : ERR_OVER;
        paddr   <= '0;
      end else if (ctrl.finishPte) begin
        errCode <= pteDenied ? ERR_ACCESS : ERR_OK;
        paddr   <= pteDenied ? '0 : {ppnQ, offset};
      end
    end
  end

  // R8: the result strobe lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3 and R4: segment faults finish without touching memory
  assert_fault_no_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && (errCode == ERR_BADSEG || errCode == ERR_OVER)) |-> !$past(memRdEn));

  // R5: the low byte is read at the next address on the next cycle
  assert_read_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && !$past(memRdEn)) |=> (memRdEn && memRdAddr == $past(memRdAddr) + PA_W'(1)));

  // R1: a successful result keeps the request's offset
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == ERR_OK) |-> (paddr[OFF_W-1:0] == offset));

endmodule

// File: rtl/seg_page_xlat.sv
module seg_page_xlat
  import xlat_pkg::*;
#(
  parameter int SEG_W  = 2,
  parameter int PAGE_W = 6,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 8,
  localparam int VA_W  = SEG_W + PAGE_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W,
  localparam int LIM_W = PAGE_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             segWrEn,
  input  logic [SEG_W-1:0] segWrIdx,
  input  logic [PA_W-1:0]  segWrBase,
  input  logic [LIM_W-1:0] segWrLimit,
  input  logic             segWrValid,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic [VA_W-1:0]  reqVaddr,
  output logic             reqReady,
  output logic             memRdEn,
  output logic [PA_W-1:0]  memRdAddr,
  input  logic [PPN_W-1:0] memRdData,
  output logic             done,
  output logic [1:0]       errCode,
  output logic [PA_W-1:0]  paddr
);

  xlat_ctrl_t ctrl;
  logic       segFault;

  xlat_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .segFault (segFault),
    .reqReady (reqReady),
    .ctrl     (ctrl)
  );

  xlat_datapath #(
    .SEG_W  (SEG_W),
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W),
    .PPN_W  (PPN_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .segWrEn    (segWrEn),
    .segWrIdx   (segWrIdx),
    .segWrBase  (segWrBase),
    .segWrLimit (segWrLimit),
    .segWrValid (segWrValid),
    .reqStore   (reqStore),
    .reqVaddr   (reqVaddr),
    .memRdData  (memRdData),
    .segFault   (segFault),
    .memRdEn    (memRdEn),
    .memRdAddr  (memRdAddr),
    .done       (done),
    .errCode    (errCode),
    .paddr      (paddr)
  );

endmodule

// File: tb/test_seg_page_xlat.sv
module test_seg_page_xlat;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrIdx = '0;
  logic [19:0] segWrBase = '0;
  logic [6:0]  segWrLimit = '0;
  logic        segWrValid = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqStore = 1'b0;
  logic [19:0] reqVaddr = '0;
  logic        reqReady;
  logic        memRdEn;
  logic [19:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic        done;
  logic [1:0]  errCode;
  logic [19:0] paddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seg_page_xlat i_seg_page_xlat (
    .clk(clk), .rstN(rstN),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .segWrBase(segWrBase),
    .segWrLimit(segWrLimit), .segWrValid(segWrValid),
    .reqValid(reqValid), .reqStore(reqStore), .reqVaddr(reqVaddr),
    .reqReady(reqReady), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .done(done), .errCode(errCode), .paddr(paddr)
  );

  // behavioural memory image and segment copy
  logic [7:0] memImg [int];
  logic [19:0] mBase [4];
  int          mLimit [4];
  bit          mValid [4];

  function automatic logic [7:0] rdByte(input logic [19:0] a);
    if (memImg.exists(int'(a))) return memImg[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= rdByte(memRdAddr);

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [19:0] va(input int s, input int p, input int o);
    return {2'(s), 6'(p), 12'(o)};
  endfunction

  task automatic setSeg(input int idx, input logic [19:0] base, input int lim, input bit v);
    segWrEn = 1'b1; segWrIdx = 2'(idx); segWrBase = base;
    segWrLimit = 7'(lim); segWrValid = v;
    @(negedge clk);
    segWrEn = 1'b0;
    mBase[idx] = base; mLimit[idx] = lim; mValid[idx] = v;
  endtask

  // drives one request and compares every cycle against the model
  task automatic doReq(input bit st, input logic [19:0] v, input bit poke, input string rq);
    int s = int'(v[19:18]);
    int p = int'(v[17:12]);
    logic [19:0] ea;
    logic [7:0]  hi, lo;
    int lat;
    logic [1:0]  expErr;
    logic [19:0] expPa;
    ea = '0; expPa = '0;
    if (!mValid[s]) begin
      lat = 1; expErr = 2'b01;
    end else if (p >= mLimit[s]) begin
      lat = 1; expErr = 2'b10;
    end else begin
      lat = 3;
      ea = mBase[s] + 20'(2 * p);
      hi = rdByte(ea); lo = rdByte(ea + 20'd1);
      if (!lo[0] || (st && !lo[1])) expErr = 2'b11;
      else begin expErr = 2'b00; expPa = {hi, v[11:0]}; end
    end
    chk(reqReady == 1'b1, rq, "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqStore = st; reqVaddr = v;
    for (int c = 0; c <= lat; c++) begin
      @(negedge clk);
      if (poke && c < lat) begin
        reqValid = 1'b1; reqStore = ~st; reqVaddr = v ^ 20'h3F0FF;
      end else reqValid = 1'b0;
      chk(done == (c == lat), rq, "done timing", int'(done), int'(c == lat));
      chk(reqReady == (c == lat), rq, "ready while busy", int'(reqReady), int'(c == lat));
      chk(memRdEn == (lat == 3 && c < 2), rq, "read strobe", int'(memRdEn), int'(lat == 3 && c < 2));
      if (lat == 3 && c < 2)
        chk(memRdAddr == ea + 20'(c), rq, "read address", int'(memRdAddr), int'(ea + 20'(c)));
      if (c == lat) begin
        chk(errCode == expErr, rq, "error code", int'(errCode), int'(expErr));
        chk(paddr == expPa, rq, "physical address", int'(paddr), int'(expPa));
      end
    end
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mBase[i] = '0; mLimit[i] = 0; mValid[i] = 0; end
    // page entries: high byte = frame, low byte flags (bit0 valid, bit1 writeable)
    memImg[32'h02030] = 8'h5C; memImg[32'h02031] = 8'h03;
    memImg[32'h02032] = 8'h7A; memImg[32'h02033] = 8'h01;
    memImg[32'h02034] = 8'h11; memImg[32'h02035] = 8'h02;
    memImg[32'h0206E] = 8'hE4; memImg[32'h0206F] = 8'h03;
    memImg[32'h00000] = 8'h9B; memImg[32'h00001] = 8'hFF;
    memImg[32'h0007C] = 8'h3D; memImg[32'h0007D] = 8'h01;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(reqReady == 1'b1, "R10", "ready after reset", int'(reqReady), 1);
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
    chk(memRdEn == 1'b0, "R10", "read after reset", int'(memRdEn), 0);
    doReq(0, va(0, 0, 'h100), 0, "R10 segments invalid after reset");

    setSeg(0, 20'h02030, 'h20, 1);
    setSeg(1, 20'h01020, 'h10, 1);
    setSeg(2, 20'h01040, 'h01, 0);
    setSeg(3, 20'hFFFFE, 64, 1);

    doReq(0, va(0, 0, 'hABC), 0, "R1 load ok");
    doReq(1, va(0, 0, 'h123), 0, "R8 store ok");
    doReq(0, va(0, 1, 'hFFF), 0, "R7 load read-only page");
    doReq(1, va(0, 1, 'h010), 0, "R7 store read-only page");
    doReq(0, va(0, 2, 'h004), 0, "R6 load invalid page");
    doReq(1, va(0, 2, 'h004), 0, "R6 store invalid page");
    doReq(0, va(0, 'h1F, 'h000), 0, "R4 last legal page");
    doReq(0, va(0, 'h20, 'h000), 0, "R4 first illegal page");
    doReq(0, va(2, 0, 'h777), 0, "R3 invalid segment");
    doReq(1, va(2, 5, 'h777), 0, "R4 bad segment precedence");
    doReq(1, va(3, 1, 'h456), 0, "R5 wrapped entry address, R7 flag bits ignored");
    doReq(0, va(3, 63, 'h001), 0, "R4 count 64 admits page 63");
    doReq(0, va(0, 0, 'h2A2), 1, "R9 request while busy ignored");
    doReq(1, va(2, 0, 'h010), 1, "R9 busy poke on fault");
    setSeg(1, 20'h01020, 0, 1);
    doReq(0, va(1, 0, 'h000), 0, "R2 R4 count zero");
    setSeg(1, 20'h02030, 4, 1);
    doReq(0, va(1, 0, 'h5A5), 0, "R2 rewritten base");
    setSeg(0, 20'h02030, 'h20, 0);
    doReq(0, va(0, 0, 'h5A5), 0, "R2 segment invalidated");

    @(negedge clk);
    chk(done == 1'b0, "R8", "no stray done", int'(done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule